// File: doc/BRIEF.md
# Paged Indirect Register Access Sequencer

This engine sits on the host side of a switch management link. A single request names a wide switch register by an 8-bit page and an 8-bit offset, gives an access width of 8, 16, 32, 48 or 64 bits, a direction and write data. The engine turns that request into a string of 16-bit transactions on a management register port aimed at one fixed management address. It returns the assembled read data together with a completion or error status.

The engine remembers the page it last selected and skips the page selection when the next request stays on the same page. After issuing the access command it reads the command register back until the device reports that the command has finished. It waits a programmable number of cycles between these reads and gives up with an error after a fixed number of attempts. A failed transaction on the management port ends the request at once with an error.

The controller has eight states. IDLE accepts a request and moves to PAGE on a page miss, or else to WDATA for writes and CMD for reads. PAGE writes the page register, then goes to WDATA or CMD. WDATA writes one data word per transaction and goes to CMD after the last word. CMD writes the command register and goes to POLL. POLL reads the command register and goes to GAP while the device is busy, to RDATA for a finished read, or to DONE for a finished write or an exhausted retry count. GAP waits and then returns to POLL. RDATA reads one data word per transaction and goes to DONE after the last word. Any port error goes directly to DONE. DONE presents the response for one cycle and returns to IDLE.

Top module: `paged_reg_seq`

## Requirements
- R1: A page-select write (management address 0x10, data = page in bits 15:8, bits 7:1 zero, bit 0 = 1) is issued only when the requested page differs from the remembered page. The remembered page takes the new value only when that write completes without error.
- R2: After reset the remembered page is 0xFF. A first request for any other page therefore writes the page register, and a first request for page 0xFF does not.
- R3: For a write, the data words go to addresses 0x18, 0x19, ... in ascending order before the command, least significant word first. Width code 0 (8 bit) and 1 (16 bit) use one word, code 2 (32 bit) two, code 3 (48 bit) three and code 4 (64 bit) four.
- R4: The command is a write to address 0x11 carrying the register offset in bits 15:8 and zero in bits 7:2. Bit 0 is set for a write request and bit 1 for a read request.
- R5: After the command, address 0x11 is read until its bits 1:0 are both zero. If those bits are still nonzero after 5 reads, the request ends with an error and no data word is read.
- R6: Between two consecutive reads of 0x11, the port valid stays low for exactly poll_gap+1 cycles. Other back-to-back transactions of one request follow each other with no idle cycle.
- R7: A read fetches its data words from 0x18 upward only after the completion read. The word from 0x18+i appears in rsp_rdata bits 16i+15:16i, and unused upper bits are zero.
- R8: An 8-bit read (width code 0) returns only bits 7:0 of the word at 0x18, with rsp_rdata bits 63:8 zero.
- R9: A transaction that completes with mg_err ends the request with rsp_err set and issues no further transaction. If the failing transaction was the page write, the remembered page is unchanged.
- R10: req_ready is high only in IDLE, and a request is taken only then. req_valid and request fields are ignored while busy. rsp_valid is a single-cycle pulse followed by req_ready.
- R11: While mg_valid is high and mg_done is low, mg_addr, mg_write and mg_wdata hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request taken this cycle |
| req_page | input | 8 | Register page |
| req_reg | input | 8 | Register offset within page |
| req_width | input | 3 | Width code 0..4 = 8/16/32/48/64 bits |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 64 | Write data, least significant bits used |
| poll_gap | input | 16 | Idle cycles minus one between completion reads |
| mg_valid | output | 1 | Management transaction pending |
| mg_write | output | 1 | 1 = write transaction, 0 = read |
| mg_addr | output | 5 | Management register address |
| mg_wdata | output | 16 | Management write data |
| mg_done | input | 1 | Transaction completes this cycle |
| mg_err | input | 1 | Completing transaction failed |
| mg_rdata | input | 16 | Read data, valid with mg_done |
| rsp_valid | output | 1 | Response pulse |
| rsp_err | output | 1 | Request ended with error |
| rsp_rdata | output | 64 | Assembled read data |

## Verification
The hardest situations to reach are those that depend on the remote device: the fifth busy completion read that must end in an error, and a port error landing on one chosen transaction such as the page write, a middle data word or a poll. The bench responder therefore takes, for each request, a count of busy replies to give and the index of the transaction that should fail, with random reply latency. Random requests sweep these knobs and the poll gap. Directed cases then place the error on the page write followed by a same-page request, run exactly 4 and exactly 5 busy replies, and make the first requests after reset use page 0xFF and page 0x00.

// File: rtl/prs_pkg.sv
package prs_pkg;

    localparam int WORD_W     = 16;
    localparam int MAX_WORDS  = 4;
    localparam int DATA_W     = WORD_W * MAX_WORDS;
    localparam int IDX_W      = $clog2(MAX_WORDS);
    localparam int PAGE_W     = 8;
    localparam int MADDR_W    = 5;

    localparam logic [MADDR_W-1:0] ADR_PAGE = 5'h10;
    localparam logic [MADDR_W-1:0] ADR_CMD  = 5'h11;
    localparam logic [MADDR_W-1:0] ADR_DATA = 5'h18;

    localparam logic [PAGE_W-1:0]  PAGE_RESET = 8'hFF;

    typedef enum logic [2:0] {
        SZ_8  = 3'd0,
        SZ_16 = 3'd1,
        SZ_32 = 3'd2,
        SZ_48 = 3'd3,
        SZ_64 = 3'd4
    } size_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PAGE,
        ST_WDATA,
        ST_CMD,
        ST_POLL,
        ST_GAP,
        ST_RDATA,
        ST_DONE
    } seq_state_e;

    function automatic logic [IDX_W-1:0] last_word_idx(input size_e sz);
        case (sz)
            SZ_8, SZ_16: last_word_idx = IDX_W'(0);
            SZ_32:       last_word_idx = IDX_W'(1);
            SZ_48:       last_word_idx = IDX_W'(2);
            default:     last_word_idx = IDX_W'(MAX_WORDS - 1);
        endcase
    endfunction

endpackage

// File: rtl/prs_page_cache.sv
module prs_page_cache #(
    parameter int PAGE_W = 8,
    parameter logic [PAGE_W-1:0] RESET_PAGE = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAGE_W-1:0] want_page,
    input  logic              commit,
    input  logic [PAGE_W-1:0] commit_page,
    output logic [PAGE_W-1:0] cur_page,
    output logic              miss
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_page <= RESET_PAGE;
        end else if (commit) begin
            cur_page <= commit_page;
        end
    end

    assign miss = (want_page != cur_page);

    // R1 / R9: remembered page moves only on a successful page write
    a_r1_page_held: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(cur_page));

endmodule

// File: rtl/prs_poll_ctrl.sv
module prs_poll_ctrl #(
    parameter int MAX_TRIES = 5,
    parameter int GAP_W     = 16,
    localparam int TRY_W    = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             busy_seen,
    input  logic             in_gap,
    input  logic [GAP_W-1:0] gap_len,
    output logic             exhausted,
    output logic             gap_over
);

    logic [TRY_W-1:0] tries;
    logic [GAP_W-1:0] gap_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tries <= '0;
        end else if (start) begin
            tries <= '0;
        end else if (busy_seen && !exhausted) begin
            tries <= tries + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_cnt <= '0;
        end else if (busy_seen) begin
            gap_cnt <= gap_len;
        end else if (in_gap && gap_cnt != '0) begin
            gap_cnt <= gap_cnt - 1'b1;
        end
    end

    assign exhausted = (tries == TRY_W'(MAX_TRIES - 1));
    assign gap_over  = (gap_cnt == '0);

    // R5: attempt count never passes the retry limit
    a_r5_tries_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        tries <= TRY_W'(MAX_TRIES - 1));

    // R6: the wait counter never moves while outside the wait state and not loading
    a_r6_gap_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_gap && !busy_seen) |=> $stable(gap_cnt));

endmodule

// File: rtl/prs_word_lanes.sv
module prs_word_lanes #(
    parameter int NUM_WORDS = 4,
    parameter int WORD_W    = 16,
    localparam int IDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1,
    localparam int DATA_W   = NUM_WORDS * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  sel,
    output logic [WORD_W-1:0] sel_word,
    input  logic              clr,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    output logic [DATA_W-1:0] rd_data
);

    logic [WORD_W-1:0] wr_words [NUM_WORDS];
    logic [WORD_W-1:0] lane_q   [NUM_WORDS];

    for (genvar g = 0; g < NUM_WORDS; g++) begin : g_lane
        assign wr_words[g] = wr_data[g*WORD_W +: WORD_W];

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q[g] <= '0;
            end else if (clr) begin
                lane_q[g] <= '0;
            end else if (load && sel == IDX_W'(g)) begin
                lane_q[g] <= load_word;
            end
        end

        assign rd_data[g*WORD_W +: WORD_W] = lane_q[g];
    end

    assign sel_word = wr_words[sel];

endmodule

// File: rtl/paged_reg_seq.sv
module paged_reg_seq
    import prs_pkg::*;
#(
    parameter int MAX_TRIES = 5,
    parameter int GAP_W     = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [PAGE_W-1:0]  req_page,
    input  logic [7:0]         req_reg,
    input  logic [2:0]         req_width,
    input  logic               req_write,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [GAP_W-1:0]   poll_gap,
    output logic               mg_valid,
    output logic               mg_write,
    output logic [MADDR_W-1:0] mg_addr,
    output logic [WORD_W-1:0]  mg_wdata,
    input  logic               mg_done,
    input  logic               mg_err,
    input  logic [WORD_W-1:0]  mg_rdata,
    output logic               rsp_valid,
    output logic               rsp_err,
    output logic [DATA_W-1:0]  rsp_rdata
);

    seq_state_e state_q, state_d;

    logic [PAGE_W-1:0] q_page;
    logic [7:0]        q_reg;
    size_e             q_size;
    logic              q_write;
    logic [DATA_W-1:0] q_wdata;
    logic [IDX_W-1:0]  widx;
    logic              err_q;

    logic              page_miss;
    logic [PAGE_W-1:0] cache_page;
    logic              xfer_ok;
    logic              xfer_bad;
    logic              poll_busy;
    logic              last_word;
    logic              poll_exhausted;
    logic              gap_over;
    logic [WORD_W-1:0] stage_word;
    logic [DATA_W-1:0] lanes_data;
    logic              accept;

    assign accept    = (state_q == ST_IDLE) && req_valid;
    assign xfer_ok   = mg_done && !mg_err;
    assign xfer_bad  = mg_done && mg_err;
    assign poll_busy = (mg_rdata[1:0] != 2'b00);
    assign last_word = (widx == last_word_idx(q_size));

    prs_page_cache #(
        .PAGE_W     (PAGE_W),
        .RESET_PAGE (PAGE_RESET)
    ) i_page_cache (
        .clk         (clk),
        .rst_n       (rst_n),
        .want_page   (req_page),
        .commit      (state_q == ST_PAGE && xfer_ok),
        .commit_page (q_page),
        .cur_page    (cache_page),
        .miss        (page_miss)
    );

    prs_poll_ctrl #(
        .MAX_TRIES (MAX_TRIES),
        .GAP_W     (GAP_W)
    ) i_poll_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (state_q == ST_CMD && xfer_ok),
        .busy_seen (state_q == ST_POLL && xfer_ok && poll_busy),
        .in_gap    (state_q == ST_GAP),
        .gap_len   (poll_gap),
        .exhausted (poll_exhausted),
        .gap_over  (gap_over)
    );

    prs_word_lanes #(
        .NUM_WORDS (MAX_WORDS),
        .WORD_W    (WORD_W)
    ) i_word_lanes (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_data   (q_wdata),
        .sel       (widx),
        .sel_word  (stage_word),
        .clr       (accept),
        .load      (state_q == ST_RDATA && xfer_ok),
        .load_word (mg_rdata),
        .rd_data   (lanes_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (page_miss)      state_d = ST_PAGE;
                    else if (req_write) state_d = ST_WDATA;
                    else                state_d = ST_CMD;
                end
            end
            ST_PAGE: begin
                if (xfer_bad)     state_d = ST_DONE;
                else if (xfer_ok) state_d = q_write ? ST_WDATA : ST_CMD;
            end
            ST_WDATA: begin
                if (xfer_bad)                  state_d = ST_DONE;
                else if (xfer_ok && last_word) state_d = ST_CMD;
            end
            ST_CMD: begin
                if (xfer_bad)     state_d = ST_DONE;
                else if (xfer_ok) state_d = ST_POLL;
            end
            ST_POLL: begin
                if (xfer_bad) begin
                    state_d = ST_DONE;
                end else if (xfer_ok) begin
                    if (poll_busy)    state_d = poll_exhausted ? ST_DONE : ST_GAP;
                    else if (q_write) state_d = ST_DONE;
                    else              state_d = ST_RDATA;
                end
            end
            ST_GAP: begin
                if (gap_over) state_d = ST_POLL;
            end
            ST_RDATA: begin
                if (xfer_bad)                  state_d = ST_DONE;
                else if (xfer_ok && last_word) state_d = ST_DONE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // request latch, word index and error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_page  <= '0;
            q_reg   <= '0;
            q_size  <= SZ_8;
            q_write <= 1'b0;
            q_wdata <= '0;
            widx    <= '0;
            err_q   <= 1'b0;
        end else begin
            if (accept) begin
                q_page  <= req_page;
                q_reg   <= req_reg;
                q_size  <= size_e'(req_width);
                q_write <= req_write;
                q_wdata <= req_wdata;
                widx    <= '0;
                err_q   <= 1'b0;
            end
            if ((state_q == ST_WDATA || state_q == ST_RDATA) && xfer_ok) begin
                widx <= last_word ? '0 : widx + 1'b1;
            end
            if (state_q == ST_POLL && xfer_ok && !poll_busy) begin
                widx <= '0;
            end
            if (state_q != ST_IDLE && state_q != ST_GAP && state_q != ST_DONE && xfer_bad) begin
                err_q <= 1'b1;
            end
            if (state_q == ST_POLL && xfer_ok && poll_busy && poll_exhausted) begin
                err_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        mg_valid  = 1'b0;
        mg_write  = 1'b0;
        mg_addr   = '0;
        mg_wdata  = '0;
        req_ready = 1'b0;
        rsp_valid = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
            end
            ST_PAGE: begin
                mg_valid = 1'b1;
                mg_write = 1'b1;
                mg_addr  = ADR_PAGE;
                mg_wdata = {q_page, 7'b0, 1'b1};
            end
            ST_WDATA: begin
                mg_valid = 1'b1;
                mg_write = 1'b1;
                mg_addr  = ADR_DATA + MADDR_W'(widx);
                mg_wdata = stage_word;
            end
            ST_CMD: begin
                mg_valid = 1'b1;
                mg_write = 1'b1;
                mg_addr  = ADR_CMD;
                mg_wdata = {q_reg, 6'b0, ~q_write, q_write};
            end
            ST_POLL: begin
                mg_valid = 1'b1;
                mg_addr  = ADR_CMD;
            end
            ST_GAP: begin
            end
            ST_RDATA: begin
                mg_valid = 1'b1;
                mg_addr  = ADR_DATA + MADDR_W'(widx);
            end
            ST_DONE: begin
                rsp_valid = 1'b1;
            end
        endcase
    end

    assign rsp_err   = err_q;
    assign rsp_rdata = (q_size == SZ_8) ? {{(DATA_W-8){1'b0}}, lanes_data[7:0]} : lanes_data;

    // R11: a pending transaction keeps its fields until it completes
    a_r11_hold_fields: assert property (@(posedge clk) disable iff (!rst_n)
        (mg_valid && !mg_done) |=> (mg_valid && $stable(mg_addr) && $stable(mg_write) && $stable(mg_wdata)));

    // R10: no port activity while idle
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mg_valid);

    // R10: response is a single pulse followed by idle
    a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> (!rsp_valid && req_ready));

    // R4: command word carries exactly one direction bit and clear middle bits
    a_r4_cmd_word: assert property (@(posedge clk) disable iff (!rst_n)
        (mg_valid && mg_write && mg_addr == ADR_CMD) |-> ($countones(mg_wdata[1:0]) == 1 && mg_wdata[7:2] == 6'b0));

    // R1: page word has the enable bit and clear low bits
    a_r1_page_word: assert property (@(posedge clk) disable iff (!rst_n)
        (mg_valid && mg_write && mg_addr == ADR_PAGE) |-> (mg_wdata[7:0] == 8'h01 && mg_wdata[15:8] == q_page));

    // R8: byte reads return nothing above bit 7
    a_r8_byte_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !q_write && q_size == SZ_8) |-> (rsp_rdata[DATA_W-1:8] == '0));

    // R1: a page write only happens when the request's page differs from the cache
    a_r1_page_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (mg_valid && mg_addr == ADR_PAGE) |-> (cache_page != q_page));

endmodule

// File: tb/test_paged_reg_seq.sv
module test_paged_reg_seq;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [7:0]  req_page;
    logic [7:0]  req_reg;
    logic [2:0]  req_width;
    logic        req_write;
    logic [63:0] req_wdata;
    logic [15:0] poll_gap;
    logic        mg_valid;
    logic        mg_write;
    logic [4:0]  mg_addr;
    logic [15:0] mg_wdata;
    logic        mg_done;
    logic        mg_err;
    logic [15:0] mg_rdata;
    logic        rsp_valid;
    logic        rsp_err;
    logic [63:0] rsp_rdata;

    always #2 clk = ~clk;

    paged_reg_seq i_paged_reg_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_page  (req_page),
        .req_reg   (req_reg),
        .req_width (req_width),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .poll_gap  (poll_gap),
        .mg_valid  (mg_valid),
        .mg_write  (mg_write),
        .mg_addr   (mg_addr),
        .mg_wdata  (mg_wdata),
        .mg_done   (mg_done),
        .mg_err    (mg_err),
        .mg_rdata  (mg_rdata),
        .rsp_valid (rsp_valid),
        .rsp_err   (rsp_err),
        .rsp_rdata (rsp_rdata)
    );

    int n_chk  = 0;
    int n_fail = 0;

    // observed and expected transaction logs
    logic [4:0]  lg_addr [0:63];
    logic        lg_wr   [0:63];
    logic [15:0] lg_data [0:63];
    int          lg_gap  [0:63];
    int          lg_n;
    logic [4:0]  ex_addr [0:63];
    logic        ex_wr   [0:63];
    logic [15:0] ex_data [0:63];
    int          ex_n;

    // responder knobs
    int          busy_left;
    int          err_at;
    logic [15:0] rwords [0:3];
    bit          in_txn;
    int          lat;
    int          idle;
    int          cur_txn;
    logic [7:0]  model_page;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // management port responder, acting at the falling edge
    always @(negedge clk) begin
        logic [15:0] rnd;
        rnd     = 16'($urandom);
        mg_done = 1'b0;
        mg_err  = 1'b0;
        if (!rst_n) begin
            in_txn = 1'b0;
            idle   = 0;
        end else if (mg_valid) begin
            if (!in_txn) begin
                if (lg_n < 64) begin
                    lg_addr[lg_n] = mg_addr;
                    lg_wr[lg_n]   = mg_write;
                    lg_data[lg_n] = mg_wdata;
                    lg_gap[lg_n]  = idle;
                end
                cur_txn = lg_n;
                lg_n++;
                in_txn = 1'b1;
                lat    = int'($urandom % 3);
                idle   = 0;
            end
            if (lat == 0) begin
                mg_done = 1'b1;
                in_txn  = 1'b0;
                if (cur_txn == err_at) mg_err = 1'b1;
                if (!mg_write && mg_addr == 5'h11) begin
                    if (busy_left > 0) begin
                        mg_rdata  = {rnd[15:2], 2'(1 + ($urandom % 3))};
                        busy_left = busy_left - 1;
                    end else begin
                        mg_rdata = {rnd[15:2], 2'b00};
                    end
                end else if (!mg_write && mg_addr >= 5'h18 && mg_addr <= 5'h1b) begin
                    mg_rdata = rwords[mg_addr - 5'h18];
                end else begin
                    mg_rdata = rnd;
                end
            end else begin
                lat = lat - 1;
            end
        end else begin
            idle++;
        end
    end

    task automatic push(input logic [4:0] a, input logic w, input logic [15:0] d);
        ex_addr[ex_n] = a;
        ex_wr[ex_n]   = w;
        ex_data[ex_n] = d;
        ex_n++;
    endtask

    // expected sequence from the requirements
    task automatic build_exp(input logic [7:0] pg, input logic [7:0] rg, input logic [2:0] sz,
                             input bit wr, input logic [63:0] wd, input int busy, input int errat,
                             output bit e_err, output logic [63:0] e_data);
        int  nw;
        bit  stop;
        bit  polled;
        ex_n   = 0;
        e_err  = 1'b0;
        e_data = '0;
        stop   = 1'b0;
        polled = 1'b0;
        nw = (sz <= 3'd1) ? 1 : (sz == 3'd2) ? 2 : (sz == 3'd3) ? 3 : 4;
        if (pg != model_page) begin
            push(5'h10, 1'b1, {pg, 8'h01});
            if (ex_n - 1 == errat) begin e_err = 1'b1; stop = 1'b1; end
            else model_page = pg;
        end
        if (!stop && wr) begin
            for (int i = 0; i < nw; i++) begin
                if (!stop) begin
                    push(5'h18 + 5'(i), 1'b1, wd[16*i +: 16]);
                    if (ex_n - 1 == errat) begin e_err = 1'b1; stop = 1'b1; end
                end
            end
        end
        if (!stop) begin
            push(5'h11, 1'b1, {rg, 6'b0, ~wr, wr});
            if (ex_n - 1 == errat) begin e_err = 1'b1; stop = 1'b1; end
        end
        for (int t = 0; t < 5; t++) begin
            if (!stop && !polled) begin
                push(5'h11, 1'b0, 16'h0);
                if (ex_n - 1 == errat) begin e_err = 1'b1; stop = 1'b1; end
                else if (t >= busy) polled = 1'b1;
                else if (t == 4) begin e_err = 1'b1; stop = 1'b1; end
            end
        end
        if (!stop && !wr) begin
            for (int i = 0; i < nw; i++) begin
                if (!stop) begin
                    push(5'h18 + 5'(i), 1'b0, 16'h0);
                    if (ex_n - 1 == errat) begin e_err = 1'b1; stop = 1'b1; end
                end
            end
        end
        for (int i = 0; i < nw; i++) e_data[16*i +: 16] = rwords[i];
        if (sz == 3'd0) e_data = e_data & 64'hFF;
    endtask

    function automatic string tag_of(input logic [4:0] a, input logic w);
        if (a == 5'h10)      return "R1";
        else if (a == 5'h11) return w ? "R4" : "R5";
        else                 return w ? "R3" : "R7";
    endfunction

    task automatic do_reset();
        rst_n     = 1'b0;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n      = 1'b1;
        model_page = 8'hFF;
        @(negedge clk);
    endtask

    task automatic run_req(input logic [7:0] pg, input logic [7:0] rg, input logic [2:0] sz,
                           input bit wr, input logic [63:0] wd, input int busy, input int errat,
                           input logic [15:0] gap, input bit noise);
        bit          e_err;
        logic [63:0] e_data;
        busy_left = busy;
        err_at    = errat;
        for (int i = 0; i < 4; i++) rwords[i] = 16'($urandom);
        poll_gap = gap;
        lg_n     = 0;
        build_exp(pg, rg, sz, wr, wd, busy, errat, e_err, e_data);
        while (!req_ready) @(negedge clk);
        req_page  = pg;
        req_reg   = rg;
        req_width = sz;
        req_write = wr;
        req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = noise;
        while (!rsp_valid) begin
            if (noise) begin
                req_page  = 8'($urandom);
                req_reg   = 8'($urandom);
                req_width = 3'($urandom % 5);
                req_write = 1'($urandom);
                req_wdata = {32'($urandom), 32'($urandom)};
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        // R9 / R5: status
        chk(rsp_err == e_err, (errat >= 0) ? "R9" : "R5", "rsp_err", 64'(rsp_err), 64'(e_err));
        if (!e_err && !wr)
            chk(rsp_rdata == e_data, (sz == 3'd0) ? "R8" : "R7", "rsp_rdata", rsp_rdata, e_data);
        chk(lg_n == ex_n, noise ? "R10" : "R9", "transaction count", 64'(lg_n), 64'(ex_n));
        for (int i = 0; i < ex_n && i < lg_n; i++) begin
            chk(lg_addr[i] == ex_addr[i] && lg_wr[i] == ex_wr[i] && (!ex_wr[i] || lg_data[i] == ex_data[i]),
                tag_of(ex_addr[i], ex_wr[i]), $sformatf("txn %0d addr/dir/data", i),
                {42'h0, lg_addr[i], lg_wr[i], lg_data[i]}, {42'h0, ex_addr[i], ex_wr[i], ex_data[i]});
            if (i > 0) begin
                int eg;
                eg = (ex_addr[i] == 5'h11 && !ex_wr[i] && ex_addr[i-1] == 5'h11 && !ex_wr[i-1])
                     ? int'(gap) + 1 : 0;
                chk(lg_gap[i] == eg, "R6", $sformatf("idle before txn %0d", i), 64'(lg_gap[i]), 64'(eg));
            end
        end
        @(negedge clk);
        chk(req_ready == 1'b1 && rsp_valid == 1'b0, "R10", "ready after response",
            {62'h0, req_ready, rsp_valid}, 64'h2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        mg_done   = 1'b0;
        mg_err    = 1'b0;
        mg_rdata  = '0;
        req_page  = '0;
        req_reg   = '0;
        req_width = '0;
        req_write = 1'b0;
        req_wdata = '0;
        poll_gap  = '0;
        busy_left = 0;
        err_at    = -1;
        lg_n      = 0;
        do_reset();

        // reset state
        chk(req_ready == 1'b1 && mg_valid == 1'b0 && rsp_valid == 1'b0, "R10", "reset outputs",
            {61'h0, req_ready, mg_valid, rsp_valid}, 64'h4);

        // R2: page 0xFF right after reset needs no page write
        run_req(8'hFF, 8'h20, 3'd1, 1'b0, 64'h0, 0, -1, 16'd0, 1'b0);
        chk(lg_addr[0] == 5'h11, "R2", "first txn for page FF", 64'(lg_addr[0]), 64'h11);

        // R2: page 0x00 after a fresh reset writes the page
        do_reset();
        run_req(8'h00, 8'h04, 3'd4, 1'b1, 64'h1122_3344_5566_7788, 0, -1, 16'd1, 1'b0);
        chk(lg_addr[0] == 5'h10, "R2", "first txn for page 00", 64'(lg_addr[0]), 64'h10);

        // R1: same page again, no page write
        run_req(8'h00, 8'h08, 3'd3, 1'b0, 64'h0, 1, -1, 16'd2, 1'b0);
        chk(lg_addr[0] == 5'h11, "R1", "hit skips page write", 64'(lg_addr[0]), 64'h11);

        // R8: byte read
        run_req(8'h00, 8'h10, 3'd0, 1'b0, 64'h0, 0, -1, 16'd0, 1'b0);

        // R5: four busy replies then success, five busy replies then error
        run_req(8'h02, 8'h30, 3'd2, 1'b0, 64'h0, 4, -1, 16'd3, 1'b0);
        run_req(8'h02, 8'h31, 3'd2, 1'b0, 64'h0, 5, -1, 16'd0, 1'b0);
        chk(lg_n == 6, "R5", "no data read after timeout", 64'(lg_n), 64'd6);

        // R9: page write fails, cache untouched, next request rewrites page
        run_req(8'h07, 8'h01, 3'd1, 1'b1, 64'hBEEF, 0, 0, 16'd0, 1'b0);
        run_req(8'h07, 8'h01, 3'd1, 1'b1, 64'hBEEF, 0, -1, 16'd0, 1'b0);
        chk(lg_addr[0] == 5'h10, "R9", "page rewritten after failed page write", 64'(lg_addr[0]), 64'h10);

        // R9: error on a middle data word
        run_req(8'h07, 8'h02, 3'd4, 1'b1, 64'hAAAA_BBBB_CCCC_DDDD, 0, 2, 16'd0, 1'b0);

        // R10: request inputs toggled while busy are ignored
        run_req(8'h09, 8'h44, 3'd3, 1'b0, 64'h0, 2, -1, 16'd1, 1'b1);

        // random mix
        for (int n = 0; n < 80; n++) begin
            logic [7:0] pg;
            int         bz;
            int         ea;
            pg = 8'($urandom % 4);
            if (($urandom % 8) == 0) pg = 8'hFF;
            bz = int'($urandom % 7);
            ea = (($urandom % 5) == 0) ? int'($urandom % 10) : -1;
            run_req(pg, 8'($urandom), 3'($urandom % 5), 1'($urandom),
                    {32'($urandom), 32'($urandom)}, bz, ea, 16'($urandom % 5), 1'($urandom % 4 == 0));
        end

        finish_run();
    end

endmodule